// File: doc/BRIEF.md
# Dual Auto-Reload Timer/Counter with Split Mode

The block holds two 16-bit timer/counter units fed by one shared clock prescaler. Each unit counts in one of two ways. In timer function it counts prescaled clock ticks. In counter function it counts falling edges seen on its own external pin. Each unit has its own 16-bit reload value. A 2-bit mode field selects one of four modes:

- a timer whose width can be set from 9 to 16 bits;
- 16-bit auto-reload;
- 8-bit auto-reload on the low byte;
- split mode, where the low and high bytes act as two independent 8-bit reloading timers.

With one unit split and the other unit left whole, the block provides two 8-bit timers and one 16-bit timer.

Each unit has a run bit and an optional gate. When the gate is enabled, an external level can halt the unit. Each overflow sets a sticky flag and flips a per-unit output pin. Software reaches every register through a byte-wide port. Writes take effect at the clock edge. Reads are combinational on the address.

Top module: `tmr_pair`

## Requirements
- R1: After reset, every register reads 0x00 and both toggle outputs are low. The byte addresses are:
  - 0: control;
  - 1 and 2: configuration for unit 0 and unit 1;
  - 3: prescaler;
  - 4+4u+0: count low byte of unit u;
  - 4+4u+1: count high byte of unit u;
  - 4+4u+2: reload low byte of unit u;
  - 4+4u+3: reload high byte of unit u.
- R2: The prescaler holds code p in bits [3:0] (p from 0 to 15). It produces one tick every p+1 clocks. Writing the prescaler register restarts its phase, so that the first tick comes p+1 clocks after the write edge.
- R3: Counter function is selected by bit 2 of a unit's configuration. In this function the pin is sampled on every clock. One is counted for each high sample followed by a low sample. The count changes on the second rising edge at which the pin is sampled low, which is one clock after detection. At most one count is made per two clocks.
- R4: Bit u of the control register is the run bit of unit u. Nothing counts while this bit is 0. When the gate bit (configuration bit 3) is set, the low counter also needs its gate pin high.
- R5: Mode 0 (configuration bits [1:0]=0) is a timer of width W=9+c, where c is configuration bits [6:4]. When the low W bits of the count are all ones, an event sets them to 0 and signals overflow. Otherwise the count becomes (count+1) with only the low W bits kept.
- R6: In mode 1, an event at 0xFFFF loads the 16-bit reload value and signals overflow.
- R7: In mode 2, the low byte counts, and an event at 0xFF loads the low reload byte and signals overflow. The high byte keeps its value.
- R8: In mode 3, the low byte behaves as in mode 2. The high byte counts prescaled ticks whenever the unit's run bit is set. At 0xFF it loads the high reload byte and sets control bit 4+u.
- R9: An overflow sets control bit 2+u. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged.
- R10: Output tog_out[u] flips on every overflow of unit u's low counter.
- R11: A write to either count byte of a unit stores the written data. It also cancels every count that unit would make at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| ext_cnt | input | 2 | Count pins, one per unit |
| ext_gate | input | 2 | Gate pins, one per unit |
| tog_out | output | 2 | Overflow toggle outputs |

## Verification
Random cases draw a unit, a mode, a width code, a prescaler ratio, a start value, a reload value and a run length. Start values are biased just below the wrap point so that overflows happen. The random mix tells apart prescaler phase errors, width masking and reload-versus-wrap behaviour. Directed cases cover:
- the 9-bit wrap with stray upper bits set;
- single pin pulses and pin pulses at the maximum rate, which separate the one-clock detection latency from double or missed counts;
- gate levels against the run bit;
- flag write-one versus write-zero;
- a byte write landing on an active count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int N_UNITS = 2;
  localparam int BYTE_W  = 8;
  localparam int CNT_W   = 2 * BYTE_W;
  localparam int PS_W    = 4;
  localparam int WCODE_W = 3;
  localparam int ADDR_W  = 4;
  localparam int MAX_WCODE = (1 << WCODE_W) - 1;

  localparam int A_CTRL  = 0;
  localparam int A_CFG0  = 1;
  localparam int A_PRESC = N_UNITS + 1;
  localparam int A_UNIT0 = N_UNITS + 2;
  localparam int UNIT_SPAN = 4;

  typedef enum logic [1:0] {
    MD_VARW  = 2'd0,
    MD_RLD16 = 2'd1,
    MD_RLD8  = 2'd2,
    MD_SPLIT = 2'd3
  } mode_e;

  typedef struct packed {
    logic [WCODE_W-1:0] wcode;
    logic               gate_en;
    logic               csel;
    mode_e              mode;
  } unit_cfg_t;

  localparam int CFG_W = $bits(unit_cfg_t);
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PS_W-1:0] ratio,
  input  logic            restart,
  output logic            tick
);
  logic [PS_W-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == ratio);

  always_comb begin
    if (restart || tick) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ratio != '0 && !restart) |=> !tick); // R2
  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> (cnt_q <= ratio)); // R2
endmodule

// File: rtl/tmr_edge_det.sv
module tmr_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic [1:0] smp_q, smp_d;

  always_comb smp_d = {smp_q[0], pin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp_q <= '0;
    else        smp_q <= smp_d;
  end

  assign fall = smp_q[1] & ~smp_q[0];

  AST_FALL_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall); // R3
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              fall,
  input  logic              gate_pin,
  input  logic              run,
  input  unit_cfg_t         cfg,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  rld,
  output logic [CNT_W-1:0]  cnt,
  output logic              ovf,
  output logic              ovf_h,
  output logic              tog
);
  localparam logic [BYTE_W-1:0] BYTE_TOP = '1;
  localparam logic [CNT_W-1:0]  WORD_TOP = '1;

  logic [BYTE_W-1:0]  lo_q, lo_d, hi_q, hi_d;
  logic               tog_q, tog_d;
  logic               wr_any, src, inc, inc_h;
  logic [CNT_W-1:0]   cnt_q, vmask;
  logic [WCODE_W-1:0] shamt;

  assign cnt_q  = {hi_q, lo_q};
  assign wr_any = wr_lo | wr_hi;
  assign src    = cfg.csel ? fall : tick;
  assign inc    = run && (!cfg.gate_en || gate_pin) && src && !wr_any;
  assign inc_h  = run && tick && !wr_any;
  assign shamt  = WCODE_W'(MAX_WCODE) - cfg.wcode;
  assign vmask  = WORD_TOP >> shamt;

  always_comb begin
    lo_d  = lo_q;
    hi_d  = hi_q;
    ovf   = 1'b0;
    ovf_h = 1'b0;
    case (cfg.mode)
      MD_VARW: begin
        if (inc) begin
          if ((cnt_q & vmask) == vmask) begin
            ovf          = 1'b1;
            {hi_d, lo_d} = '0;
          end else begin
            {hi_d, lo_d} = (cnt_q + 1'b1) & vmask;
          end
        end
      end
      MD_RLD16: begin
        if (inc) begin
          if (cnt_q == WORD_TOP) begin
            ovf          = 1'b1;
            {hi_d, lo_d} = rld;
          end else begin
            {hi_d, lo_d} = cnt_q + 1'b1;
          end
        end
      end
      MD_RLD8, MD_SPLIT: begin
        if (inc) begin
          if (lo_q == BYTE_TOP) begin
            ovf  = 1'b1;
            lo_d = rld[BYTE_W-1:0];
          end else begin
            lo_d = lo_q + 1'b1;
          end
        end
        if (cfg.mode == MD_SPLIT && inc_h) begin
          if (hi_q == BYTE_TOP) begin
            ovf_h = 1'b1;
            hi_d  = rld[CNT_W-1:BYTE_W];
          end else begin
            hi_d = hi_q + 1'b1;
          end
        end
      end
      default: ;
    endcase
    if (wr_lo) lo_d = wdata;
    if (wr_hi) hi_d = wdata;
    tog_d = tog_q ^ ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      tog_q <= 1'b0;
    end else begin
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      tog_q <= tog_d;
    end
  end

  assign cnt = cnt_q;
  assign tog = tog_q;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_any) |=> $stable(cnt_q)); // R4
  AST_VARW_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == MD_VARW && inc) |=> ((cnt_q & ~$past(vmask)) == '0)); // R5
  AST_RELOAD16: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && cfg.mode == MD_RLD16) |=> (cnt_q == $past(rld))); // R6
  AST_RLD8_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == MD_RLD8 && !wr_any) |=> (hi_q == $past(hi_q))); // R7
  AST_SPLIT_RLD: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_h |=> (hi_q == $past(rld[CNT_W-1:BYTE_W]))); // R8
  AST_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (tog_q != $past(tog_q))); // R10
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (lo_q == $past(wdata))); // R11
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BYTE_W-1:0]  wdata,
  output logic [BYTE_W-1:0]  rdata,
  input  logic [N_UNITS-1:0] ext_cnt,
  input  logic [N_UNITS-1:0] ext_gate,
  output logic [N_UNITS-1:0] tog_out
);
  logic [N_UNITS-1:0] run_q, run_d, flag_q, flag_d, flagh_q, flagh_d;
  logic [N_UNITS-1:0] ovf_u, ovfh_u, fall_u;
  logic [PS_W-1:0]    presc_q, presc_d;
  logic               wr_ctrl, wr_presc, tick;
  unit_cfg_t          cfg_q [N_UNITS];
  logic [CNT_W-1:0]   rld_q [N_UNITS];
  logic [CNT_W-1:0]   cnt_u [N_UNITS];

  assign wr_ctrl  = wr_en && (addr == ADDR_W'(A_CTRL));
  assign wr_presc = wr_en && (addr == ADDR_W'(A_PRESC));

  tmr_prescaler #(.PS_W(PS_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .ratio(presc_q), .restart(wr_presc), .tick(tick)
  );

  // control and prescaler registers
  always_comb begin
    run_d   = wr_ctrl ? wdata[N_UNITS-1:0] : run_q;
    presc_d = wdata[PS_W-1:0];
    for (int i = 0; i < N_UNITS; i++) begin
      flag_d[i]  = ovf_u[i]  | (flag_q[i]  & ~(wr_ctrl & ~wdata[N_UNITS+i]));
      flagh_d[i] = ovfh_u[i] | (flagh_q[i] & ~(wr_ctrl & ~wdata[2*N_UNITS+i]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      flag_q  <= '0;
      flagh_q <= '0;
      presc_q <= '0;
    end else begin
      run_q   <= run_d;
      flag_q  <= flag_d;
      flagh_q <= flagh_d;
      if (wr_presc) presc_q <= presc_d;
    end
  end

  for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
    localparam int BASE = A_UNIT0 + UNIT_SPAN * g;
    logic      wr_cfg, wr_lo, wr_hi, wr_rl, wr_rh;
    unit_cfg_t cfg_d;
    logic [CNT_W-1:0] rld_d;

    assign wr_cfg = wr_en && (addr == ADDR_W'(A_CFG0 + g));
    assign wr_lo  = wr_en && (addr == ADDR_W'(BASE));
    assign wr_hi  = wr_en && (addr == ADDR_W'(BASE + 1));
    assign wr_rl  = wr_en && (addr == ADDR_W'(BASE + 2));
    assign wr_rh  = wr_en && (addr == ADDR_W'(BASE + 3));

    always_comb begin
      cfg_d = unit_cfg_t'(wdata[CFG_W-1:0]);
      rld_d = rld_q[g];
      if (wr_rl) rld_d[BYTE_W-1:0]     = wdata;
      if (wr_rh) rld_d[CNT_W-1:BYTE_W] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[g] <= '0;
        rld_q[g] <= '0;
      end else begin
        if (wr_cfg)         cfg_q[g] <= cfg_d;
        if (wr_rl || wr_rh) rld_q[g] <= rld_d;
      end
    end

    tmr_edge_det u_edge (
      .clk(clk), .rst_n(rst_n), .pin(ext_cnt[g]), .fall(fall_u[g])
    );

    tmr_unit u_unit (
      .clk(clk), .rst_n(rst_n), .tick(tick), .fall(fall_u[g]),
      .gate_pin(ext_gate[g]), .run(run_q[g]), .cfg(cfg_q[g]),
      .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(wdata), .rld(rld_q[g]),
      .cnt(cnt_u[g]), .ovf(ovf_u[g]), .ovf_h(ovfh_u[g]), .tog(tog_out[g])
    );

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_u[g] |=> flag_q[g]); // R9
    AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[g] && !wr_ctrl) |=> flag_q[g]); // R9
    AST_FLAGH_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ovfh_u[g] |=> flagh_q[g]); // R8
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(A_CTRL))  rdata = BYTE_W'({flagh_q, flag_q, run_q});
    if (addr == ADDR_W'(A_PRESC)) rdata = BYTE_W'(presc_q);
    for (int i = 0; i < N_UNITS; i++) begin
      if (addr == ADDR_W'(A_CFG0 + i)) rdata = BYTE_W'(cfg_q[i]);
      if (addr == ADDR_W'(A_UNIT0 + UNIT_SPAN * i))     rdata = cnt_u[i][BYTE_W-1:0];
      if (addr == ADDR_W'(A_UNIT0 + UNIT_SPAN * i + 1)) rdata = cnt_u[i][CNT_W-1:BYTE_W];
      if (addr == ADDR_W'(A_UNIT0 + UNIT_SPAN * i + 2)) rdata = rld_q[i][BYTE_W-1:0];
      if (addr == ADDR_W'(A_UNIT0 + UNIT_SPAN * i + 3)) rdata = rld_q[i][CNT_W-1:BYTE_W];
    end
  end
endmodule

// File: tb/tmr_pair_bench.sv
module tmr_pair_bench;
  logic       clk, rst_n, wr_en;
  logic [3:0] addr;
  logic [7:0] wdata, rdata;
  logic [1:0] ext_cnt, ext_gate, tog_out;
  int n_tests, n_fail;
  bit done;

  tmr_pair u_tmr_pair (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ext_cnt(ext_cnt), .ext_gate(ext_gate), .tog_out(tog_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; addr = 4'(a); wdata = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    addr = 4'(a);
    #1 d = rdata;
  endtask

  task automatic rd16(input int u, output logic [15:0] v);
    logic [7:0] l, h;
    rd(4 + 4*u, l);
    rd(5 + 4*u, h);
    v = {h, l};
  endtask

  function automatic int ticks(input int p, input int n);
    return (p == 0) ? n : (n + 1) / (p + 1);
  endfunction

  function automatic void model(input int md, input int wc, input logic [15:0] st,
      input logic [15:0] rl, input int k, output logic [15:0] v, output int o, output int oh);
    logic [15:0] m;
    v = st; o = 0; oh = 0;
    m = 16'hFFFF >> (7 - wc);
    for (int i = 0; i < k; i++) begin
      case (md)
        0: if ((v & m) == m) begin v = 16'h0; o++; end else v = (v + 16'd1) & m;
        1: if (v == 16'hFFFF) begin v = rl; o++; end else v = v + 16'd1;
        default: begin
          if (v[7:0] == 8'hFF) begin v[7:0] = rl[7:0]; o++; end else v[7:0] = v[7:0] + 8'd1;
          if (md == 3) begin
            if (v[15:8] == 8'hFF) begin v[15:8] = rl[15:8]; oh++; end
            else v[15:8] = v[15:8] + 8'd1;
          end
        end
      endcase
    end
  endfunction

  task automatic setup(input int u, input int cfg, input int p,
      input logic [15:0] st, input logic [15:0] rl);
    wr(0, 0);
    wr(0, 0);
    wr(1 + u, cfg);
    wr(4 + 4*u, st[7:0]);
    wr(5 + 4*u, st[15:8]);
    wr(6 + 4*u, rl[7:0]);
    wr(7 + 4*u, rl[15:8]);
    wr(3, p);
  endtask

  task automatic run_case(input int u, input int md, input int wc, input int p,
      input logic [15:0] st, input logic [15:0] rl, input int n, input string tag);
    logic [15:0] v, exp_v;
    logic [7:0] c;
    int o, oh;
    logic t0;
    setup(u, (wc << 4) | md, p, st, rl);
    t0 = tog_out[u];
    wr(0, 1 << u);
    repeat (n) @(negedge clk);
    model(md, wc, st, rl, ticks(p, n), exp_v, o, oh);
    rd16(u, v);
    check(tag, v, exp_v);
    rd(0, c);
    check("R9 flag", c[2+u], (o > 0));
    check("R10 toggle", tog_out[u], t0 ^ o[0]);
    if (md == 3) check("R8 high flag", c[4+u], (oh > 0));
  endtask

  initial begin
    logic [15:0] v, st, rl;
    logic [7:0]  d;
    int dummy;
    n_tests = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    ext_cnt = 2'b11; ext_gate = 2'b00;
    dummy = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 12; a++) begin
      rd(a, d);
      check("R1 reset reg", d, 0);
    end
    check("R1 reset toggle", tog_out, 0);

    // R5: 9-bit wrap and stray upper bits
    run_case(0, 0, 0, 0, 16'h01FE, 16'h0, 3, "R5 9-bit wrap");
    run_case(0, 0, 0, 0, 16'hFE05, 16'h0, 1, "R5 upper bits masked");
    // R2: prescaler ratio
    run_case(1, 1, 0, 4, 16'h1000, 16'h0, 23, "R2 ratio 5");
    run_case(1, 1, 0, 15, 16'hFFFE, 16'h8000, 50, "R2 ratio 16 R6");
    // R6 R7 R8 directed
    run_case(0, 1, 0, 0, 16'hFFFD, 16'hABCD, 6, "R6 reload16");
    run_case(1, 2, 0, 0, 16'h55FC, 16'h77F0, 9, "R7 reload8");
    run_case(0, 3, 0, 1, 16'hFDFE, 16'h10E0, 12, "R8 split");

    // random cases
    for (int it = 0; it < 24; it++) begin
      int u, md, wc, p, n;
      u  = $urandom % 2;
      md = $urandom % 4;
      wc = $urandom % 8;
      p  = $urandom % 16;
      n  = 20 + ($urandom % 280);
      st = 16'($urandom);
      if ($urandom % 2) st = 16'hFFF0 | 16'($urandom % 16);
      rl = 16'($urandom);
      run_case(u, md, wc, p, st, rl, n, "R6 R7 R8 R5 random count");
    end

    // R3: counter function
    setup(0, 32'h5, 0, 16'h0010, 16'h0);
    wr(0, 1);
    ext_cnt[0] = 1'b0;
    @(negedge clk);
    rd16(0, v); check("R3 no count yet", v, 16'h0010);
    @(negedge clk);
    rd16(0, v); check("R3 count after detect", v, 16'h0011);
    repeat (3) @(negedge clk);
    rd16(0, v); check("R3 held low", v, 16'h0011);
    for (int k = 0; k < 5; k++) begin
      ext_cnt[0] = 1'b1; @(negedge clk);
      ext_cnt[0] = 1'b0; @(negedge clk);
    end
    ext_cnt[0] = 1'b1;
    repeat (3) @(negedge clk);
    rd16(0, v); check("R3 max rate", v, 16'h0016);

    // R4: gate and run
    setup(1, 32'h9, 0, 16'h0100, 16'h0);
    ext_gate[1] = 1'b0;
    wr(0, 2);
    repeat (10) @(negedge clk);
    rd16(1, v); check("R4 gate low", v, 16'h0100);
    ext_gate[1] = 1'b1;
    repeat (10) @(negedge clk);
    rd16(1, v); check("R4 gate high", v, 16'h010A);
    ext_gate[1] = 1'b0;
    repeat (5) @(negedge clk);
    rd16(1, v); check("R4 gate low again", v, 16'h010A);
    ext_gate[1] = 1'b1;
    wr(0, 0);
    rd16(1, st);
    repeat (5) @(negedge clk);
    rd16(1, v); check("R4 run off", v, st);

    // R9: flag write-one keeps, write-zero clears
    setup(0, 2, 0, 16'h00FE, 16'h00F0);
    wr(0, 1);
    repeat (4) @(negedge clk);
    wr(0, 8'h3C);
    rd(0, d); check("R9 write one keeps", d[2], 1);
    wr(0, 8'h00);
    rd(0, d); check("R9 write zero clears", d[2], 0);

    // R11: write priority
    setup(0, 1, 0, 16'h1200, 16'h0);
    wr(0, 1);
    repeat (3) @(negedge clk);
    rd16(0, st);
    wr(4, 8'h10);
    rd16(0, v); check("R11 low write wins", v, {st[15:8], 8'h10});
    wr(5, 8'hAB);
    rd16(0, v); check("R11 high write wins", v, 16'hAB10);
    @(negedge clk);
    rd16(0, v); check("R11 resumes", v, 16'hAB11);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule